// File: doc/BRIEF.md
# Logical-to-Physical Block Remapper

This block translates logical block numbers into physical block numbers for a page-oriented flash store. Every logical block starts out mapped to the physical block with the same number. A small group of physical blocks above the logical range is held back as spares and is never visible as a logical block. A host sends a logical number on the lookup port and gets the physical number back one cycle later. Lookups keep working while a relocation is in progress.

When the host reports that a logical block has shown a correctable error, the block takes the lowest-numbered free spare. It then asks an external data mover to copy from the current physical block to that spare, using a request/acknowledge pair. The table entry changes only when the mover acknowledges. Physical block 0 is always trusted: it is never relocated and never given out as a spare. If no spare is left, a sticky exhausted flag is raised and the table stays as it was.

Before normal use, the host raises a load mode and feeds in the list of blocks that were found bad at manufacture. A bad block inside the logical range is moved at once to a spare, with no copy. A bad spare is taken out of the pool.

Top module: `blk_remap_xlate`

## Requirements
- R1: After reset every logical block L looks up to physical block L, `pool_exhausted` is 0 and `cp_req` is 0.
- R2: A lookup sampled with `lk_valid` high at a clock edge gives `lk_done` high and the translated number on `lk_pblk` after that same edge, for exactly one cycle.
- R3: Spares are the physical blocks LOG_BLOCKS to LOG_BLOCKS+SPARE_BLOCKS-1. The free spare with the lowest number is always taken first.
- R4: A bad report accepted at edge k (load mode low, block idle, logical block not 0, a spare free) raises `cp_req` after edge k+1. At that point `cp_src` is the block's current physical number and `cp_dst` is the allocated spare. All three are held steady until `cp_ack` is sampled high, and `cp_req` drops after that edge.
- R5: Until the acknowledge is sampled, lookups return the old physical block, and this includes a lookup sampled at the acknowledge edge. Lookups sampled at any later edge return the spare.
- R6: Bad reports that arrive while a relocation is being fetched or copied are ignored, including a report for the block being moved.
- R7: A bad report or factory entry that names block 0 is ignored, and logical block 0 always looks up to physical 0.
- R8: A relocation or factory entry that finds no free spare sets `pool_exhausted`. The flag stays set until reset, the table is not changed and no copy is requested.
- R9: In load mode, a factory entry naming physical block P (1 ≤ P < LOG_BLOCKS) whose logical block P has not been moved remaps P to the lowest free spare with no copy. A lookup sampled two edges after the entry returns the spare. A repeated entry for an already moved block is ignored.
- R10: In load mode, a factory entry naming a spare removes that spare from the pool.
- R11: Bad reports are ignored while load mode is high, and factory entries are ignored while it is low.
- R12: A block that was already moved can be moved again. Its copy source is then the spare it currently uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_lblk | input | LBW | Logical block to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_pblk | output | PBW | Translated physical block |
| load_mode | input | 1 | High while the factory bad list is being loaded |
| fb_valid | input | 1 | Factory bad entry strobe |
| fb_pblk | input | PBW | Physical block marked bad at manufacture |
| bad_valid | input | 1 | Correctable-error report strobe |
| bad_lblk | input | LBW | Logical block that reported the error |
| cp_req | output | 1 | Copy request to the data mover |
| cp_src | output | PBW | Copy source physical block |
| cp_dst | output | PBW | Copy destination spare |
| cp_ack | input | 1 | Copy finished |
| pool_exhausted | output | 1 | Sticky: a spare was needed and none was free |

## Verification
A lookup result is due right after the edge that samples the lookup. A copy request is due after the second edge following an accepted report, and a factory remap becomes visible to a lookup sampled two edges after the entry. The bench drives every input on the falling edge and reads outputs on the next falling edge, so each check lands in the cycle where the result is due. The acknowledge edge is checked by issuing a lookup in the same cycle and expecting the old block, then a second lookup expecting the spare.

// File: rtl/blk_remap_pkg.sv
package blk_remap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_COPY  = 2'd2
  } remap_state_t;
endpackage

// File: rtl/blk_remap_store.sv
// Map storage: spare index per logical block (RAM-inferable, two ports)
// plus a reset-cleared "moved" flag per logical block.
module blk_remap_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] a_addr,
  output logic [IW-1:0] a_idx,
  output logic          a_moved,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [IW-1:0] b_widx,
  output logic [IW-1:0] b_idx,
  output logic          b_moved
);
  logic [IW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] moved, moved_nxt;

  // Port A: read only (host lookups); port B: read/write (controller).
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_widx;
    a_idx <= mem[a_addr];
    b_idx <= mem[b_addr];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_moved
    assign moved_nxt[g] = moved[g] | (b_we && (b_addr == AW'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      moved   <= '0;
      a_moved <= 1'b0;
      b_moved <= 1'b0;
    end else begin
      moved   <= moved_nxt;
      a_moved <= moved[a_addr];
      b_moved <= moved[b_addr];
    end
  end
endmodule

// File: rtl/blk_spare_pool.sv
// Free-spare bitmap with a lowest-index-first picker.
module blk_spare_pool #(
  parameter int SLOTS = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          retire,
  input  logic [IW-1:0] retire_idx,
  output logic          has_free,
  output logic [IW-1:0] low_idx
);
  logic [SLOTS-1:0] free_q, free_nxt;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign free_nxt[g] = free_q[g]
                       & ~(take   && (low_idx    == IW'(g)))
                       & ~(retire && (retire_idx == IW'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= free_nxt;
  end

  always_comb begin
    low_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_q[i]) low_idx = IW'(i);
    end
    has_free = |free_q;
  end
endmodule

// File: rtl/blk_remap_ctrl.sv
// Sequencer for factory-list loading and error-driven relocation.
module blk_remap_ctrl
  import blk_remap_pkg::*;
#(
  parameter int LOG_BLOCKS   = 16,
  parameter int SPARE_BLOCKS = 4,
  parameter int LBW          = 4,
  parameter int PBW          = 5,
  parameter int SIW          = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_mode,
  input  logic           fb_valid,
  input  logic [PBW-1:0] fb_pblk,
  input  logic           bad_valid,
  input  logic [LBW-1:0] bad_lblk,
  input  logic           cp_ack,
  input  logic           has_free,
  input  logic [SIW-1:0] low_idx,
  input  logic [SIW-1:0] b_idx,
  input  logic           b_moved,
  output logic           take,
  output logic           retire,
  output logic [SIW-1:0] retire_idx,
  output logic [LBW-1:0] b_addr,
  output logic           b_we,
  output logic [SIW-1:0] b_widx,
  output logic           cp_req,
  output logic [PBW-1:0] cp_src,
  output logic [PBW-1:0] cp_dst,
  output logic           pool_exhausted
);
  localparam int PHYS = LOG_BLOCKS + SPARE_BLOCKS;

  remap_state_t   st;
  logic [LBW-1:0] tgt;
  logic           is_fact;
  logic [SIW-1:0] dst_idx;
  logic           idle, acc_bad, acc_fact, fb_in_log, fb_in_spare;

  assign idle        = (st == ST_IDLE);
  assign fb_in_log   = (fb_pblk != '0) && ({1'b0, fb_pblk} < (PBW+1)'(LOG_BLOCKS));
  assign fb_in_spare = ({1'b0, fb_pblk} >= (PBW+1)'(LOG_BLOCKS)) &&
                       ({1'b0, fb_pblk} <  (PBW+1)'(PHYS));
  assign acc_bad     = idle && !load_mode && bad_valid && (bad_lblk != '0);
  assign acc_fact    = idle &&  load_mode && fb_valid  && fb_in_log;
  assign retire      = idle &&  load_mode && fb_valid  && fb_in_spare;
  assign retire_idx  = SIW'(fb_pblk - PBW'(LOG_BLOCKS));
  assign b_addr      = idle ? (acc_bad ? bad_lblk : LBW'(fb_pblk)) : tgt;
  assign cp_req      = (st == ST_COPY);

  always_comb begin
    take   = 1'b0;
    b_we   = 1'b0;
    b_widx = low_idx;
    if (st == ST_FETCH) begin
      if (!(is_fact && b_moved) && has_free) begin
        take = 1'b1;
        b_we = is_fact;
      end
    end else if (st == ST_COPY) begin
      b_widx = dst_idx;
      b_we   = cp_ack;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      tgt            <= '0;
      is_fact        <= 1'b0;
      dst_idx        <= '0;
      cp_src         <= '0;
      cp_dst         <= '0;
      pool_exhausted <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (acc_bad || acc_fact) begin
            tgt     <= b_addr;
            is_fact <= acc_fact;
            st      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (is_fact && b_moved) begin
            st <= ST_IDLE;
          end else if (!has_free) begin
            pool_exhausted <= 1'b1;
            st             <= ST_IDLE;
          end else if (is_fact) begin
            st <= ST_IDLE;
          end else begin
            cp_src  <= b_moved ? PBW'(LOG_BLOCKS) + PBW'(b_idx) : PBW'(tgt);
            cp_dst  <= PBW'(LOG_BLOCKS) + PBW'(low_idx);
            dst_idx <= low_idx;
            st      <= ST_COPY;
          end
        end
        ST_COPY: begin
          if (cp_ack) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_remap_xlate.sv
module blk_remap_xlate #(
  parameter int LOG_BLOCKS   = 16,
  parameter int SPARE_BLOCKS = 4,
  parameter int LBW          = $clog2(LOG_BLOCKS),
  parameter int PBW          = $clog2(LOG_BLOCKS + SPARE_BLOCKS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lk_valid,
  input  logic [LBW-1:0] lk_lblk,
  output logic           lk_done,
  output logic [PBW-1:0] lk_pblk,
  input  logic           load_mode,
  input  logic           fb_valid,
  input  logic [PBW-1:0] fb_pblk,
  input  logic           bad_valid,
  input  logic [LBW-1:0] bad_lblk,
  output logic           cp_req,
  output logic [PBW-1:0] cp_src,
  output logic [PBW-1:0] cp_dst,
  input  logic           cp_ack,
  output logic           pool_exhausted
);
  localparam int SIW = (SPARE_BLOCKS > 1) ? $clog2(SPARE_BLOCKS) : 1;

  logic [SIW-1:0] a_idx, b_idx, b_widx, low_idx, retire_idx;
  logic           a_moved, b_moved, b_we, take, retire, has_free;
  logic [LBW-1:0] b_addr, lk_lblk_q;

  blk_remap_store #(.DEPTH(LOG_BLOCKS), .AW(LBW), .IW(SIW)) u_store (
    .clk(clk), .rst(rst),
    .a_addr(lk_lblk), .a_idx(a_idx), .a_moved(a_moved),
    .b_addr(b_addr), .b_we(b_we), .b_widx(b_widx),
    .b_idx(b_idx), .b_moved(b_moved)
  );

  blk_spare_pool #(.SLOTS(SPARE_BLOCKS), .IW(SIW)) u_pool (
    .clk(clk), .rst(rst), .take(take), .retire(retire),
    .retire_idx(retire_idx), .has_free(has_free), .low_idx(low_idx)
  );

  blk_remap_ctrl #(
    .LOG_BLOCKS(LOG_BLOCKS), .SPARE_BLOCKS(SPARE_BLOCKS),
    .LBW(LBW), .PBW(PBW), .SIW(SIW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .load_mode(load_mode),
    .fb_valid(fb_valid), .fb_pblk(fb_pblk),
    .bad_valid(bad_valid), .bad_lblk(bad_lblk), .cp_ack(cp_ack),
    .has_free(has_free), .low_idx(low_idx),
    .b_idx(b_idx), .b_moved(b_moved),
    .take(take), .retire(retire), .retire_idx(retire_idx),
    .b_addr(b_addr), .b_we(b_we), .b_widx(b_widx),
    .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst),
    .pool_exhausted(pool_exhausted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done   <= 1'b0;
      lk_lblk_q <= '0;
    end else begin
      lk_done   <= lk_valid;
      lk_lblk_q <= lk_lblk;
    end
  end

  assign lk_pblk = a_moved ? PBW'(LOG_BLOCKS) + PBW'(a_idx) : PBW'(lk_lblk_q);
endmodule

// File: rtl/blk_remap_check.sv
module blk_remap_check #(
  parameter int LOG_BLOCKS   = 16,
  parameter int SPARE_BLOCKS = 4,
  parameter int LBW          = 4,
  parameter int PBW          = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           lk_valid,
  input logic [LBW-1:0] lk_lblk,
  input logic           lk_done,
  input logic [PBW-1:0] lk_pblk,
  input logic           cp_req,
  input logic [PBW-1:0] cp_src,
  input logic [PBW-1:0] cp_dst,
  input logic           cp_ack,
  input logic           pool_exhausted
);
  localparam int PHYS = LOG_BLOCKS + SPARE_BLOCKS;

  p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_done);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cp_req && !cp_ack) |=> (cp_req && $stable(cp_src) && $stable(cp_dst)));
  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (cp_req && cp_ack) |=> !cp_req);
  p_dst_spare_r3: assert property (@(posedge clk) disable iff (rst)
    cp_req |-> ({1'b0, cp_dst} >= (PBW+1)'(LOG_BLOCKS) &&
                {1'b0, cp_dst} <  (PBW+1)'(PHYS)));
  p_src_not_zero_r7: assert property (@(posedge clk) disable iff (rst)
    cp_req |-> (cp_src != '0) && (cp_src != cp_dst));
  p_zero_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_lblk == '0) |=> (lk_pblk == '0));
  p_exhaust_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    pool_exhausted |=> pool_exhausted);
endmodule

bind blk_remap_xlate blk_remap_check #(
  .LOG_BLOCKS(LOG_BLOCKS), .SPARE_BLOCKS(SPARE_BLOCKS), .LBW(LBW), .PBW(PBW)
) u_check (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_lblk(lk_lblk),
  .lk_done(lk_done), .lk_pblk(lk_pblk), .cp_req(cp_req),
  .cp_src(cp_src), .cp_dst(cp_dst), .cp_ack(cp_ack),
  .pool_exhausted(pool_exhausted)
);

// File: tb/blk_remap_xlate_test.sv
`timescale 1ns/1ps
module blk_remap_xlate_test;
  localparam int LOGB = 16;
  localparam int SPB  = 4;
  localparam int LBW  = 4;
  localparam int PBW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, load_mode = 1'b0, fb_valid = 1'b0, bad_valid = 1'b0, cp_ack = 1'b0;
  logic [LBW-1:0] lk_lblk = '0, bad_lblk = '0;
  logic [PBW-1:0] fb_pblk = '0;
  logic lk_done, cp_req, pool_exhausted;
  logic [PBW-1:0] lk_pblk, cp_src, cp_dst;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  blk_remap_xlate #(.LOG_BLOCKS(LOGB), .SPARE_BLOCKS(SPB)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_lblk(lk_lblk),
    .lk_done(lk_done), .lk_pblk(lk_pblk), .load_mode(load_mode),
    .fb_valid(fb_valid), .fb_pblk(fb_pblk), .bad_valid(bad_valid),
    .bad_lblk(bad_lblk), .cp_req(cp_req), .cp_src(cp_src),
    .cp_dst(cp_dst), .cp_ack(cp_ack), .pool_exhausted(pool_exhausted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lookup_chk(input int lb, input int exp, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_lblk = LBW'(lb);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_done === 1'b1, {req, " done"}, int'(lk_done), 1);
    chk(lk_pblk === PBW'(exp), req, int'(lk_pblk), exp);
  endtask

  task automatic factory(input int pb);
    @(negedge clk);
    fb_valid = 1'b1; fb_pblk = PBW'(pb);
    @(negedge clk);
    fb_valid = 1'b0;
    @(negedge clk);
  endtask

  // Report at edge k; result of the fetch is visible after edge k+1.
  task automatic report(input int lb);
    @(negedge clk);
    bad_valid = 1'b1; bad_lblk = LBW'(lb);
    @(negedge clk);
    bad_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pool_exhausted === 1'b0, "R1 exhausted", int'(pool_exhausted), 0);
    chk(cp_req === 1'b0, "R1 cp_req", int'(cp_req), 0);
    lookup_chk(0, 0, "R1 lookup 0");
    lookup_chk(5, 5, "R1 lookup 5");
    lookup_chk(15, 15, "R1 lookup 15");
    @(negedge clk);
    chk(lk_done === 1'b0, "R2 done single cycle", int'(lk_done), 0);
  endtask

  task automatic t_load();
    load_mode = 1'b1;
    factory(17);                        // R10: spare 17 leaves the pool
    factory(0);                         // R7: ignored
    lookup_chk(0, 0, "R7 block 0 after factory entry");
    factory(3);                         // R9: 3 -> lowest free spare 16
    lookup_chk(3, 16, "R9 factory remap");
    factory(3);                         // R9: repeat ignored
    lookup_chk(3, 16, "R9 repeat ignored");
    report(5);                          // R11: bad report in load mode
    chk(cp_req === 1'b0, "R11 report in load mode", int'(cp_req), 0);
    lookup_chk(5, 5, "R11 lookup 5 unchanged");
    load_mode = 1'b0;
    factory(6);                         // R11: factory entry outside load mode
    lookup_chk(6, 6, "R11 factory outside load mode");
  endtask

  task automatic t_remap();
    report(7);
    chk(cp_req === 1'b1, "R4 request raised", int'(cp_req), 1);
    chk(cp_src === PBW'(7), "R4 source", int'(cp_src), 7);
    chk(cp_dst === PBW'(18), "R10 R3 lowest usable spare", int'(cp_dst), 18);
    lookup_chk(7, 7, "R5 lookup during copy");
    report(9);                          // R6: ignored while copying
    report(7);                          // R6: same block ignored
    repeat (3) @(negedge clk);
    chk(cp_req === 1'b1 && cp_dst === PBW'(18), "R4 R6 request held",
        int'(cp_dst), 18);
    @(negedge clk);
    cp_ack = 1'b1; lk_valid = 1'b1; lk_lblk = LBW'(7);
    @(negedge clk);
    cp_ack = 1'b0; lk_valid = 1'b0;
    chk(lk_pblk === PBW'(7), "R5 lookup at ack edge old", int'(lk_pblk), 7);
    chk(cp_req === 1'b0, "R4 request dropped", int'(cp_req), 0);
    lookup_chk(7, 18, "R5 lookup after ack");
    repeat (3) @(negedge clk);
    chk(cp_req === 1'b0, "R6 no copy from dropped report", int'(cp_req), 0);
    lookup_chk(9, 9, "R6 block 9 not moved");
  endtask

  task automatic t_again();
    report(7);
    chk(cp_src === PBW'(18), "R12 source is current spare", int'(cp_src), 18);
    chk(cp_dst === PBW'(19), "R12 next spare", int'(cp_dst), 19);
    @(negedge clk);
    cp_ack = 1'b1;
    @(negedge clk);
    cp_ack = 1'b0;
    lookup_chk(7, 19, "R12 lookup after second move");
  endtask

  task automatic t_zero();
    report(0);
    chk(cp_req === 1'b0, "R7 report for block 0", int'(cp_req), 0);
    chk(pool_exhausted === 1'b0, "R7 no exhaustion from block 0",
        int'(pool_exhausted), 0);
  endtask

  task automatic t_exhaust();
    report(4);
    chk(pool_exhausted === 1'b1, "R8 exhausted set", int'(pool_exhausted), 1);
    chk(cp_req === 1'b0, "R8 no copy", int'(cp_req), 0);
    lookup_chk(4, 4, "R8 table unchanged");
    repeat (4) @(negedge clk);
    chk(pool_exhausted === 1'b1, "R8 sticky", int'(pool_exhausted), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_remap();
    t_again();
    t_zero();
    t_exhaust();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule